// File: doc/BRIEF.md
# SPI Flash User-Transfer Engine

This block is a register-programmed SPI master that runs one custom full-duplex burst of up to 64 bytes. Software loads a single shared byte buffer through a 32-bit register port. It then programs the number of bits to shift, chooses whether chip select is held once the burst ends, and writes a start bit. Completion is found by polling a done flag.

While the buffer bytes shift out on MOSI, the bytes that arrive on MISO overwrite the same buffer locations. After the burst, software reads the received data from the same addresses it wrote. A transfer longer than the buffer is split into chunks. Chip select stays low between chunks, and the last chunk releases it.

Top module: `sfx_user_engine`

The bus address port carries a word index, which is the byte offset divided by 4. Every offset below is a byte offset. A register bit or field not named here reads as zero. Writes to such bits have no effect.

## Requirements
- R1: After reset, spi_cs_n is 1 and spi_sck is 0. The done flag (offset 0x30, bit 4) reads 0 and the start bit (offset 0x00, bit 18) reads 0. The memory-mapped read enable (offset 0x08, bit 17) reads 1.
- R2: The buffer is sixteen 32-bit words at offsets 0x40 to 0x7C. Buffer byte k sits in word k/4 at bits 8*(k%4)+7 down to 8*(k%4). A word written while the engine is idle reads back unchanged.
- R3: The bit-count field (offset 0x20, bits 25:17) holds 8*n-1. A burst then gives exactly 8*n rising SCK edges. Buffer byte 0 goes first, and each byte goes MSB first, in SPI mode 0: MOSI changes only while SCK is low and is stable while SCK is high.
- R4: When the capture enable (offset 0x1C, bit 0) is 1, the byte sampled from MISO on the rising edges replaces buffer byte k once its 8th bit is taken. When the capture enable is 0, the buffer keeps the transmitted data.
- R5: Writing 1 to bit 18 at offset 0x00 starts a burst only if all of these hold: the engine is idle, the data-out select (offset 0x1C, bit 27) is 1, the mode bit (offset 0x30, bit 30) is 0, and the memory-mapped read enable is 0. Bit 18 reads 1 while the burst runs and 0 once it ends.
- R6: A start request does nothing in any of these cases: the memory-mapped read enable is 1, the mode bit is 1, or the data-out select is 0. No SCK edge follows, and the start bit reads 0.
- R7: A start request written during a burst is ignored. The running burst keeps its 8*n edges and does not restart.
- R8: The done flag sets when a burst ends. Writing the status word at offset 0x30 with bit 4 at 0 clears the flag. Writing bit 4 at 1 never sets it.
- R9: When the hold bit (offset 0x2C, bit 30) is 1 at start, chip select stays low after the burst. When it is 0, spi_cs_n returns to 1 at the end of the burst.
- R10: spi_cs_n falls HALF_CYC clock cycles before the first rising SCK edge. SCK rests low whenever no burst runs.
- R11: Writing 1 to bit 31 at offset 0x30 aborts any burst at once. It releases chip select, drives SCK low, and clears the done flag and the start bit. Bit 31 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 5 | Word index (byte offset / 4) for writes and reads |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| spi_miso | input | 1 | Serial data from the flash |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |

## Verification
The main transfer is run over several patterns:
- Lengths are 1, 3, 4, 5, 17 and 64 bytes. These separate a whole-word length from a partial last word and reach both ends of the buffer.
- Each pattern uses a different seed, so transmit and receive data never agree. A byte-order or bit-order fault therefore shows up as a mismatch in both the captured MOSI stream and the buffer readback.
- Capture is enabled in most runs and disabled in one, which shows whether the write-back is gated.
- The hold bit is set in one run that is followed by a release run. This shows chip-select chaining across chunks.

Directed cases cover the three ways a start can be refused, a second start during a burst, the rules for clearing the done flag, the chip-select lead time, and a soft reset partway through a burst.

// File: rtl/sfx_pkg.sv
`timescale 1ns/1ps
package sfx_pkg;
   // word indices (byte offset / 4) of the control registers
   localparam int BUS_AW = 5;
   localparam logic [BUS_AW-1:0] W_CMD   = 5'd0;   // 0x00
   localparam logic [BUS_AW-1:0] W_CTRL  = 5'd2;   // 0x08
   localparam logic [BUS_AW-1:0] W_USER  = 5'd7;   // 0x1C
   localparam logic [BUS_AW-1:0] W_BITS  = 5'd8;   // 0x20
   localparam logic [BUS_AW-1:0] W_CSCTL = 5'd11;  // 0x2C
   localparam logic [BUS_AW-1:0] W_STAT  = 5'd12;  // 0x30
   // buffer window starts at 0x40: address bit 4 of the word index
   localparam int BUF_SEL_BIT = 4;

   // bit positions
   localparam int P_GO   = 18;
   localparam int P_MMAP = 17;
   localparam int P_DOUT = 27;
   localparam int P_DIN  = 0;
   localparam int P_CNT  = 17;
   localparam int P_HOLD = 30;
   localparam int P_DONE = 4;
   localparam int P_SLV  = 30;
   localparam int P_SRST = 31;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_LOW,
      SQ_HIGH,
      SQ_TAIL
   } seq_state_e;
endpackage

// File: rtl/sfx_regs.sv
`timescale 1ns/1ps
module sfx_regs
   import sfx_pkg::*;
#(
   parameter int CNT_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [BUS_AW-1:0] addr,
   input  logic [31:0]       wdata,
   input  logic              busy,
   input  logic              done_set,
   output logic              go,
   output logic              srst,
   output logic              din_en,
   output logic              cs_hold,
   output logic [CNT_W-1:0]  bit_last,
   output logic [31:0]       rdata
);
   logic mmap_q, dout_q, din_q, hold_q, done_q, slv_q;
   logic [CNT_W-1:0] cnt_q;

   logic sel_cmd, sel_ctrl, sel_user, sel_bits, sel_csctl, sel_stat;
   assign sel_cmd   = (addr == W_CMD);
   assign sel_ctrl  = (addr == W_CTRL);
   assign sel_user  = (addr == W_USER);
   assign sel_bits  = (addr == W_BITS);
   assign sel_csctl = (addr == W_CSCTL);
   assign sel_stat  = (addr == W_STAT);

   assign go   = wr && sel_cmd && wdata[P_GO] && !busy && !mmap_q && !slv_q && dout_q;
   assign srst = wr && sel_stat && wdata[P_SRST];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mmap_q <= 1'b1;
         dout_q <= 1'b0;
         din_q  <= 1'b0;
         hold_q <= 1'b0;
         slv_q  <= 1'b0;
         cnt_q  <= '0;
      end else if (wr) begin
         if (sel_ctrl)  mmap_q <= wdata[P_MMAP];
         if (sel_user) begin
            dout_q <= wdata[P_DOUT];
            din_q  <= wdata[P_DIN];
         end
         if (sel_bits)  cnt_q  <= wdata[P_CNT +: CNT_W];
         if (sel_csctl) hold_q <= wdata[P_HOLD];
         if (sel_stat)  slv_q  <= wdata[P_SLV];
      end
   end

   // done flag: soft reset wins, then hardware set, then software clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   done_q <= 1'b0;
      else if (srst)                                done_q <= 1'b0;
      else if (done_set)                            done_q <= 1'b1;
      else if (wr && sel_stat && !wdata[P_DONE])    done_q <= 1'b0;
   end

   assign din_en   = din_q;
   assign cs_hold  = hold_q;
   assign bit_last = cnt_q;

   always_comb begin
      rdata = '0;
      unique case (1'b1)
         sel_cmd:   rdata[P_GO]   = busy;
         sel_ctrl:  rdata[P_MMAP] = mmap_q;
         sel_user: begin
            rdata[P_DOUT] = dout_q;
            rdata[P_DIN]  = din_q;
         end
         sel_bits:  rdata[P_CNT +: CNT_W] = cnt_q;
         sel_csctl: rdata[P_HOLD] = hold_q;
         sel_stat: begin
            rdata[P_SLV]  = slv_q;
            rdata[P_DONE] = done_q;
         end
         default:   rdata = '0;
      endcase
   end

   // R8: a completed burst is always visible as a set flag
   a_r8_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (done_set && !srst) |=> done_q);
   // R8: only soft reset or a status write with bit 4 low clears the flag
   a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !(wr && sel_stat)) |=> done_q);
endmodule

// File: rtl/sfx_buffer.sv
`timescale 1ns/1ps
module sfx_buffer #(
   parameter int BYTES  = 64,
   parameter int BIDX_W = 6,
   parameter int WIDX_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [WIDX_W-1:0] bus_widx,
   input  logic [31:0]       bus_wdata,
   input  logic [WIDX_W-1:0] bus_ridx,
   output logic [31:0]       bus_rdata,
   input  logic              eng_we,
   input  logic [BIDX_W-1:0] eng_widx,
   input  logic [7:0]        eng_wdata,
   input  logic [BIDX_W-1:0] eng_ridx,
   output logic [7:0]        eng_rdata
);
   logic [7:0] mem [BYTES];

   // one register per byte; engine write-back has priority over the bus
   for (genvar b = 0; b < BYTES; b++) begin : g_byte
      localparam logic [BIDX_W-1:0] BI = BIDX_W'(b);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem[b] <= 8'h00;
         else if (eng_we && eng_widx == BI)
            mem[b] <= eng_wdata;
         else if (bus_we && bus_widx == BI[BIDX_W-1:2])
            mem[b] <= bus_wdata[8*(b%4) +: 8];
      end
   end

   // little-endian lanes: byte 4w+l in bits 8l+7:8l
   for (genvar l = 0; l < 4; l++) begin : g_lane
      assign bus_rdata[8*l +: 8] = mem[{bus_ridx, 2'(l)}];
   end

   assign eng_rdata = mem[eng_ridx];
endmodule

// File: rtl/sfx_seq.sv
`timescale 1ns/1ps
module sfx_seq
   import sfx_pkg::*;
#(
   parameter int HALF_CYC = 2,
   parameter int BIDX_W   = 6,
   localparam int CNT_W   = BIDX_W + 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              srst,
   input  logic [CNT_W-1:0]  bit_last,
   input  logic              din_en,
   input  logic              cs_hold,
   input  logic              miso,
   input  logic [7:0]        rd_data,
   output logic [BIDX_W-1:0] rd_idx,
   output logic              wr_en,
   output logic [BIDX_W-1:0] wr_idx,
   output logic [7:0]        wr_data,
   output logic              busy,
   output logic              done_set,
   output logic              sck,
   output logic              cs_n,
   output logic              mosi
);
   seq_state_e       state;
   logic [CNT_W-1:0] bitidx, last_q;
   logic [7:0]       txsh, rxsh;
   logic             sck_q, cs_q, din_q, hold_q, tick;
   logic [BIDX_W-1:0] cur_byte;

   // half-period timer; a divide of one needs no counter
   if (HALF_CYC > 1) begin : g_timer
      localparam int TW = $clog2(HALF_CYC);
      logic [TW-1:0] tcnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          tcnt <= '0;
         else if (srst || state == SQ_IDLE)   tcnt <= '0;
         else if (tick)                       tcnt <= '0;
         else                                 tcnt <= tcnt + 1'b1;
      end
      assign tick = (tcnt == TW'(HALF_CYC - 1));
   end else begin : g_notimer
      assign tick = 1'b1;
   end

   assign cur_byte = bitidx[CNT_W-1:3];
   assign rd_idx   = (state == SQ_IDLE) ? '0 : cur_byte + 1'b1;
   assign wr_en    = (state == SQ_LOW) && tick && (&bitidx[2:0]) && din_q;
   assign wr_idx   = cur_byte;
   assign wr_data  = {rxsh[6:0], miso};
   assign done_set = (state == SQ_TAIL) && tick;
   assign busy     = (state != SQ_IDLE);
   assign sck      = sck_q;
   assign cs_n     = !cs_q;
   assign mosi     = txsh[7];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SQ_IDLE;
         bitidx <= '0;
         last_q <= '0;
         txsh   <= '0;
         rxsh   <= '0;
         sck_q  <= 1'b0;
         cs_q   <= 1'b0;
         din_q  <= 1'b0;
         hold_q <= 1'b0;
      end else if (srst) begin
         state <= SQ_IDLE;
         sck_q <= 1'b0;
         cs_q  <= 1'b0;
      end else begin
         unique case (state)
            SQ_IDLE: if (go) begin
               state  <= SQ_LOW;
               cs_q   <= 1'b1;
               sck_q  <= 1'b0;
               bitidx <= '0;
               last_q <= bit_last;
               din_q  <= din_en;
               hold_q <= cs_hold;
               txsh   <= rd_data;
            end
            SQ_LOW: if (tick) begin
               sck_q <= 1'b1;
               rxsh  <= {rxsh[6:0], miso};
               state <= SQ_HIGH;
            end
            SQ_HIGH: if (tick) begin
               sck_q <= 1'b0;
               if (bitidx == last_q) begin
                  state <= SQ_TAIL;
               end else begin
                  bitidx <= bitidx + 1'b1;
                  txsh   <= (&bitidx[2:0]) ? rd_data : {txsh[6:0], 1'b0};
                  state  <= SQ_LOW;
               end
            end
            SQ_TAIL: if (tick) begin
               cs_q  <= hold_q;
               state <= SQ_IDLE;
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   // R10: the serial clock rests low outside a burst
   a_r10_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_IDLE) |-> !sck_q);
   // R10: chip select is already active at every rising clock edge
   a_r10_cs_before_edge: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck_q) |-> cs_q);
   // R3: MOSI holds while SCK is high
   a_r3_mosi_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (sck_q && $past(sck_q)) |-> $stable(txsh[7]));
   // R11: soft reset leaves the engine idle with chip select released
   a_r11_srst_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (state == SQ_IDLE && !cs_q && !sck_q));
   // R9: without hold, chip select is released as the burst ends
   a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
      (done_set && !hold_q && !srst) |=> !cs_q);
endmodule

// File: rtl/sfx_user_engine.sv
`timescale 1ns/1ps
module sfx_user_engine
   import sfx_pkg::*;
#(
   parameter int BUF_BYTES = 64,
   parameter int HALF_CYC  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              spi_miso,
   output logic              spi_sck,
   output logic              spi_cs_n,
   output logic              spi_mosi
);
   localparam int BIDX_W = $clog2(BUF_BYTES);
   localparam int WIDX_W = BIDX_W - 2;
   localparam int CNT_W  = BIDX_W + 3;

   initial begin
      a_cfg_bytes: assert (BUF_BYTES >= 8 && BUF_BYTES <= 64 && (1 << BIDX_W) == BUF_BYTES)
         else $error("BUF_BYTES must be a power of two from 8 to 64");
      a_cfg_half: assert (HALF_CYC >= 1)
         else $error("HALF_CYC must be at least 1");
      a_cfg_field: assert (P_CNT + CNT_W <= 32)
         else $error("bit-count field does not fit the register");
   end

   logic go, srst, din_en, cs_hold, busy, done_set;
   logic [CNT_W-1:0]  bit_last;
   logic [31:0]       reg_rdata, buf_rdata;
   logic              eng_we;
   logic [BIDX_W-1:0] eng_widx, eng_ridx;
   logic [7:0]        eng_wdata, eng_rdata;
   logic              buf_sel;

   assign buf_sel = bus_addr[BUF_SEL_BIT];

   sfx_regs #(.CNT_W(CNT_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (bus_wr && !buf_sel),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .busy     (busy),
      .done_set (done_set),
      .go       (go),
      .srst     (srst),
      .din_en   (din_en),
      .cs_hold  (cs_hold),
      .bit_last (bit_last),
      .rdata    (reg_rdata)
   );

   sfx_buffer #(.BYTES(BUF_BYTES), .BIDX_W(BIDX_W), .WIDX_W(WIDX_W)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_wr && buf_sel),
      .bus_widx  (bus_addr[WIDX_W-1:0]),
      .bus_wdata (bus_wdata),
      .bus_ridx  (bus_addr[WIDX_W-1:0]),
      .bus_rdata (buf_rdata),
      .eng_we    (eng_we),
      .eng_widx  (eng_widx),
      .eng_wdata (eng_wdata),
      .eng_ridx  (eng_ridx),
      .eng_rdata (eng_rdata)
   );

   sfx_seq #(.HALF_CYC(HALF_CYC), .BIDX_W(BIDX_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (go),
      .srst     (srst),
      .bit_last (bit_last),
      .din_en   (din_en),
      .cs_hold  (cs_hold),
      .miso     (spi_miso),
      .rd_data  (eng_rdata),
      .rd_idx   (eng_ridx),
      .wr_en    (eng_we),
      .wr_idx   (eng_widx),
      .wr_data  (eng_wdata),
      .busy     (busy),
      .done_set (done_set),
      .sck      (spi_sck),
      .cs_n     (spi_cs_n),
      .mosi     (spi_mosi)
   );

   assign bus_rdata = buf_sel ? buf_rdata : reg_rdata;
endmodule

// File: tb/sfx_user_engine_test.sv
`timescale 1ns/1ps
module sfx_user_engine_test;
   localparam int HC = 2;
   localparam int O_CMD = 'h00, O_CTRL = 'h08, O_USER = 'h1C, O_BITS = 'h20,
                  O_CSCTL = 'h2C, O_STAT = 'h30, O_BUF = 'h40;

   typedef struct packed {
      logic [7:0] n;
      logic       din;
      logic       hold;
      logic [7:0] seed;
   } vec_t;
   localparam vec_t VEC [6] = '{
      '{8'd1,  1'b1, 1'b0, 8'h3A},
      '{8'd4,  1'b1, 1'b1, 8'h5C},
      '{8'd5,  1'b1, 1'b0, 8'hA1},
      '{8'd64, 1'b1, 1'b0, 8'h07},
      '{8'd3,  1'b0, 1'b0, 8'hE4},
      '{8'd17, 1'b1, 1'b0, 8'h92}
   };

   int checks = 0, errors = 0;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n, bus_wr, spi_miso, spi_sck, spi_cs_n, spi_mosi;
   logic [4:0]  bus_addr;
   logic [31:0] bus_wdata, bus_rdata;

   sfx_user_engine #(.BUF_BYTES(64), .HALF_CYC(HC)) uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_miso(spi_miso),
      .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi)
   );

   // flash model: drives MISO from slv_mem, shifts on the falling edge
   logic [7:0] slv_mem [64];
   logic [9:0] slv_bit = '0;
   assign spi_miso = slv_mem[slv_bit[8:3]][3'd7 - slv_bit[2:0]];
   always @(negedge spi_sck) slv_bit <= slv_bit + 1'b1;

   logic [511:0] cap;
   int  cap_n = 0;
   realtime t_csf = 0, t_rise = 0;
   bit  rise_seen = 1'b1;
   always @(posedge spi_sck) begin
      cap[cap_n[8:0]] = spi_mosi;
      cap_n = cap_n + 1;
      if (!rise_seen) begin
         t_rise = $realtime;
         rise_seen = 1'b1;
      end
   end
   always @(negedge spi_cs_n) begin
      t_csf = $realtime;
      rise_seen = 1'b0;
   end

   function automatic logic [7:0] txb(input logic [7:0] s, input int i);
      return s ^ 8'(i * 37 + 5);
   endfunction
   function automatic logic [7:0] rxb(input logic [7:0] s, input int i);
      return ~(s + 8'(i * 11));
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic bwrite(input int off, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = off[6:2]; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bread(input int off, output logic [31:0] d);
      @(negedge clk);
      bus_addr = off[6:2];
      #1 d = bus_rdata;
   endtask

   task automatic wait_done(output bit ok);
      logic [31:0] d;
      ok = 1'b0;
      for (int k = 0; k < 3000; k++) begin
         bread(O_STAT, d);
         if (d[4]) begin ok = 1'b1; return; end
      end
   endtask

   // program and launch one burst; the flash answers with rxb()
   task automatic launch(input int n, input bit din, input bit hold, input logic [7:0] s);
      for (int w = 0; w < (n + 3) / 4; w++)
         bwrite(O_BUF + 4 * w, {txb(s, 4*w+3), txb(s, 4*w+2), txb(s, 4*w+1), txb(s, 4*w)});
      for (int i = 0; i < 64; i++) slv_mem[i] = rxb(s, i);
      bwrite(O_STAT, 32'h0);
      bwrite(O_USER, (32'h1 << 27) | 32'(din));
      bwrite(O_BITS, 32'(8 * n - 1) << 17);
      bwrite(O_CSCTL, 32'(hold) << 30);
      slv_bit = '0;
      cap_n = 0;
      bwrite(O_CMD, 32'h1 << 18);
   endtask

   task automatic check_result(input int n, input bit din, input logic [7:0] s, input string req);
      int bad_tx = 0, bad_buf = 0;
      logic [31:0] d;
      for (int i = 0; i < n; i++) begin
         logic [7:0] b;
         for (int k = 0; k < 8; k++) b[7-k] = cap[8*i+k];
         if (b != txb(s, i)) bad_tx++;
      end
      chk(cap_n == 8 * n, "R3", "sck rising edges", cap_n, 8 * n);
      chk(bad_tx == 0, "R3", "mosi bytes wrong", bad_tx, 0);
      for (int i = 0; i < n; i++) begin
         bread(O_BUF + 4 * (i / 4), d);
         if (d[8*(i%4) +: 8] != (din ? rxb(s, i) : txb(s, i))) bad_buf++;
      end
      chk(bad_buf == 0, req, "buffer bytes wrong after burst", bad_buf, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d;
      bit ok;
      int c0;
      rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
      for (int i = 0; i < 64; i++) slv_mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk(spi_cs_n == 1'b1, "R1", "cs_n", spi_cs_n, 1);
      chk(spi_sck == 1'b0, "R1", "sck", spi_sck, 0);
      bread(O_STAT, d);  chk(d == 0, "R1", "status word", d, 0);
      bread(O_CMD, d);   chk(d == 0, "R1", "command word", d, 0);
      bread(O_CTRL, d);  chk(d == (32'h1 << 17), "R1", "control word", d, 32'h1 << 17);

      // R2 buffer packing and readback
      for (int w = 0; w < 16; w++) bwrite(O_BUF + 4 * w, 32'hA5000000 ^ (32'h01020304 * w));
      c0 = 0;
      for (int w = 0; w < 16; w++) begin
         bread(O_BUF + 4 * w, d);
         if (d != (32'hA5000000 ^ (32'h01020304 * w))) c0++;
      end
      chk(c0 == 0, "R2", "buffer word readback", c0, 0);

      // R6 start refused while memory-mapped read is enabled
      launch(2, 1'b1, 1'b0, 8'h10);
      repeat (30) @(negedge clk);
      chk(cap_n == 0, "R6", "edges with mmap enabled", cap_n, 0);
      bread(O_CMD, d); chk(d[18] == 1'b0, "R6", "start bit with mmap enabled", d[18], 0);
      bwrite(O_CTRL, 32'h0);

      // R6 start refused in slave mode
      bwrite(O_STAT, 32'h1 << 30);
      cap_n = 0;
      bwrite(O_CMD, 32'h1 << 18);
      repeat (30) @(negedge clk);
      chk(cap_n == 0 && spi_cs_n, "R6", "edges in slave mode", cap_n, 0);
      bwrite(O_STAT, 32'h0);

      // R6 start refused with data-out select off
      bwrite(O_USER, 32'h1);
      bwrite(O_CMD, 32'h1 << 18);
      repeat (30) @(negedge clk);
      chk(cap_n == 0 && spi_cs_n, "R6", "edges with data-out off", cap_n, 0);

      // R10 lead time from a released chip select
      launch(2, 1'b1, 1'b0, 8'h44);
      wait_done(ok);
      chk(ok, "R8", "done flag after burst", ok, 1);
      chk((t_rise - t_csf) == HC * 10.0, "R10", "cs lead time (ns)",
          longint'(t_rise - t_csf), HC * 10);
      check_result(2, 1'b1, 8'h44, "R4");

      // table of bursts: R3 R4 R9
      foreach (VEC[v]) begin
         launch(int'(VEC[v].n), VEC[v].din, VEC[v].hold, VEC[v].seed);
         wait_done(ok);
         chk(ok, "R8", "done flag in table run", ok, 1);
         check_result(int'(VEC[v].n), VEC[v].din, VEC[v].seed, "R4");
         chk(spi_cs_n == !VEC[v].hold, "R9", "cs_n after burst", spi_cs_n, !VEC[v].hold);
         bread(O_CMD, d); chk(d[18] == 1'b0, "R5", "start bit after burst", d[18], 0);
      end

      // R5 busy readback and R7 restart ignored
      launch(4, 1'b1, 1'b0, 8'h6B);
      bread(O_CMD, d); chk(d[18] == 1'b1, "R5", "start bit while busy", d[18], 1);
      repeat (20) @(negedge clk);
      bwrite(O_CMD, 32'h1 << 18);
      wait_done(ok);
      chk(cap_n == 32, "R7", "edges after second start", cap_n, 32);

      // R8 clear and no set by software
      bwrite(O_STAT, 32'h0);
      bread(O_STAT, d); chk(d[4] == 1'b0, "R8", "done after clear", d[4], 0);
      bwrite(O_STAT, 32'h10);
      bread(O_STAT, d); chk(d[4] == 1'b0, "R8", "done after writing 1", d[4], 0);

      // R11 soft reset mid-burst
      launch(8, 1'b1, 1'b1, 8'h2D);
      repeat (20) @(negedge clk);
      bwrite(O_STAT, 32'h1 << 31);
      c0 = cap_n;
      chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R11", "cs_n/sck after soft reset",
          {spi_cs_n, spi_sck}, 2'b10);
      bread(O_CMD, d);  chk(d[18] == 1'b0, "R11", "start bit after soft reset", d[18], 0);
      bread(O_STAT, d); chk(d[31] == 1'b0 && d[4] == 1'b0, "R11", "status after soft reset", d, 0);
      repeat (40) @(negedge clk);
      chk(cap_n == c0 && c0 < 64, "R11", "edges after soft reset", cap_n, c0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule